// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that takes its work from in-memory descriptors. Software places a four-word descriptor in memory, writes that descriptor's address into the channel, sets the request type to auto-request and pulses the doorbell. The channel then reads the descriptor through its memory master port. Once software sets the enable bit, the channel copies data unit by unit from the source address to the target address.

Each descriptor gives the unit size, the increment policy for each address, a unit count, an optional link to a following descriptor and an interrupt enable. The link is an offset that the block multiplies by sixteen and adds to the descriptor base address. Linked descriptors run one after another without interrupting. When the last offset is zero, the chain loops back to its first descriptor.

When a descriptor without the link bit finishes, the channel sets a terminal-count flag and, if enabled, raises its interrupt. An unaligned address or an illegal size code sets address-error and halt, stops the channel and always raises the interrupt. The same memory port serves descriptor reads and data moves. It is a single-request port: an access completes in any cycle where ready is high, and read data is valid in that same cycle.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset, every readable register reads zero, `irq` is low and `mem_req` is low.
- R2: A doorbell pulse makes the channel read four 32-bit words from the descriptor address, in this order: command, source, target, count. Afterwards the command, source and target registers read those words. The count register reads the count word, where bits 23:0 are the unit count and bits 31:24 are the link offset.
- R3: When enabled with request type 0x8, the channel copies count × unit bytes. After each unit it decrements the count by one. Each incrementing address advances by the unit size per unit, and the count reads 0 at the end.
- R4: Command bits 10:8 select the unit size: 0=4, 1=1, 2=2, 3=16, 4=32, 5=64, 6=128 bytes. Each unit is moved as beats of min(unit, 4) bytes, each beat being a read followed by a write.
- R5: Command bit 23 enables source increment and bit 22 enables target increment. An address whose bit is clear stays fixed for the whole descriptor.
- R6: When command bit 0 (link) is set and the count reaches zero, the next descriptor is read from base + (offset × 16) and runs without any interrupt between the descriptors.
- R7: When a descriptor without link finishes, status bit 3 (terminal count) is set. `irq` rises only if command bit 1 (interrupt enable) is set.
- R8: A unit whose source or target address is not aligned to the unit size moves no data. It sets status bits 4 (address error) and 2 (halt), clears bit 0 (enable) and drives `irq` high.
- R9: Writing 0 to the status register clears every flag and drops `irq`. A transfer in progress stops at the next unit boundary, so a whole number of units is moved.
- R10: With a request type other than 0x8, an enabled channel moves no data and its count does not change.
- R11: A chain whose last descriptor has link set and offset 0 loops back and fetches the first descriptor again.
- R12: Size code 7 is illegal; starting a unit with it is treated as an address error, as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 3 | Register word index (byte offset / 4): 0 source, 1 target, 2 count, 3 request type, 4 status, 5 command, 6 descriptor address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_word` |
| doorbell | input | 1 | Pulse: fetch a descriptor from the descriptor address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, data right-justified |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high |
| mem_ready | input | 1 | Access completes this cycle |
| irq | output | 1 | Level interrupt: address error, or terminal count with interrupt enable |

## Verification
Several properties are checked on every cycle by assertions. Descriptor reads are always word reads. The count drops by exactly one after the last beat of a unit. Every data write is aligned to its beat size. Terminal-count and error events set their flags, and an error also clears enable. A fetch is never started without a pending doorbell. Other behaviour can only be shown by the bench's scenarios. These include the data actually copied for each size code, fixed versus incrementing addresses, the absence of an interrupt between linked descriptors, looping chains and abort landing on a unit boundary under memory stalls. The bench checks each of these against a pattern-filled memory model.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int unsigned DW = 32;
  localparam logic [3:0] REQ_AUTO = 4'h8;

  // register word indices (byte offset / 4)
  localparam logic [2:0] RW_SRC  = 3'd0;
  localparam logic [2:0] RW_DST  = 3'd1;
  localparam logic [2:0] RW_CNT  = 3'd2;
  localparam logic [2:0] RW_RTYP = 3'd3;
  localparam logic [2:0] RW_STAT = 3'd4;
  localparam logic [2:0] RW_CMD  = 3'd5;
  localparam logic [2:0] RW_BASE = 3'd6;

  // command word fields
  localparam int unsigned CB_LINK = 0;
  localparam int unsigned CB_TIE  = 1;
  localparam int unsigned CB_DINC = 22;
  localparam int unsigned CB_SINC = 23;

  typedef enum logic [2:0] {
    E_IDLE,
    E_FETCH,
    E_RUN,
    E_RD,
    E_WR
  } eng_st_t;
endpackage

// File: rtl/dcc_unit_decode.sv
module dcc_unit_decode (
  input  logic [2:0] code,
  output logic [2:0] unit_lg,
  output logic [1:0] beat_lg,
  output logic [4:0] beats_m1,
  output logic       code_ok
);
  logic [5:0] beats;
  logic [2:0] shift;

  always_comb begin
    code_ok = 1'b1;
    case (code)
      3'd0:    unit_lg = 3'd2;
      3'd1:    unit_lg = 3'd0;
      3'd2:    unit_lg = 3'd1;
      3'd3:    unit_lg = 3'd4;
      3'd4:    unit_lg = 3'd5;
      3'd5:    unit_lg = 3'd6;
      3'd6:    unit_lg = 3'd7;
      default: begin
        unit_lg = 3'd0;
        code_ok = 1'b0;
      end
    endcase
    beat_lg  = (unit_lg >= 3'd2) ? 2'd2 : unit_lg[1:0];
    shift    = unit_lg - {1'b0, beat_lg};
    beats    = 6'd1 << shift;
    beats_m1 = 5'(beats - 6'd1);
  end
endmodule

// File: rtl/dcc_ctrl_regs.sv
module dcc_ctrl_regs #(
  parameter int unsigned RT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_rtyp,
  input  logic             we_stat,
  input  logic             we_base,
  input  logic [31:0]      wdata,
  input  logic             doorbell,
  input  logic             fetch_take,
  input  logic             ev_tc,
  input  logic             ev_err,
  input  logic             eng_idle,
  input  logic             tie,
  output logic             en,
  output logic             auto_mode,
  output logic             fetch_pend,
  output logic             abort_req,
  output logic [31:0]      desc_base,
  output logic [RT_W-1:0]  rtype,
  output logic [31:0]      status,
  output logic             irq
);
  import dcc_pkg::*;

  logic            en_q, en_d, halt_q, halt_d, tc_q, tc_d, ae_q, ae_d;
  logic            pend_q, pend_d, abort_q, abort_d;
  logic [31:0]     base_q, base_d;
  logic [RT_W-1:0] rt_q, rt_d;

  always_comb begin
    en_d    = en_q;
    halt_d  = halt_q;
    tc_d    = tc_q;
    ae_d    = ae_q;
    pend_d  = pend_q;
    abort_d = abort_q;
    base_d  = base_q;
    rt_d    = rt_q;
    if (we_rtyp) rt_d = wdata[RT_W-1:0];
    if (we_base) base_d = wdata;
    if (eng_idle) abort_d = 1'b0;
    if (fetch_take) pend_d = 1'b0;
    if (doorbell) pend_d = 1'b1;
    if (we_stat) begin
      en_d   = wdata[0];
      halt_d = halt_q & wdata[2];
      tc_d   = tc_q & wdata[3];
      ae_d   = ae_q & wdata[4];
      if (!wdata[0]) abort_d = 1'b1;
    end
    if (ev_tc) tc_d = 1'b1;
    if (ev_err) begin
      ae_d   = 1'b1;
      halt_d = 1'b1;
      en_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      halt_q  <= 1'b0;
      tc_q    <= 1'b0;
      ae_q    <= 1'b0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
      base_q  <= '0;
      rt_q    <= '0;
    end else begin
      en_q    <= en_d;
      halt_q  <= halt_d;
      tc_q    <= tc_d;
      ae_q    <= ae_d;
      pend_q  <= pend_d;
      abort_q <= abort_d;
      base_q  <= base_d;
      rt_q    <= rt_d;
    end
  end

  assign en         = en_q;
  assign auto_mode  = (rt_q == RT_W'(REQ_AUTO));
  assign fetch_pend = pend_q;
  assign abort_req  = abort_q;
  assign desc_base  = base_q;
  assign rtype      = rt_q;
  assign status     = {27'd0, ae_q, tc_q, halt_q, 1'b0, en_q};
  assign irq        = ae_q | (tc_q & tie);

  AST_TC_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tc |=> tc_q) else $error("tc flag not set"); // R7
  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |=> (ae_q && halt_q && !en_q)) else $error("error did not halt"); // R8
  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_take |-> pend_q) else $error("fetch without doorbell"); // R2
endmodule

// File: rtl/dcc_engine.sv
module dcc_engine #(
  parameter int unsigned CNT_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        auto_mode,
  input  logic        fetch_pend,
  input  logic        abort_req,
  input  logic [31:0] desc_base,
  input  logic        sw_we,
  input  logic [2:0]  sw_idx,
  input  logic [31:0] sw_wdata,
  output logic        fetch_take,
  output logic        ev_tc,
  output logic        ev_err,
  output logic        idle,
  output logic [31:0] src_o,
  output logic [31:0] dst_o,
  output logic [31:0] cnt_o,
  output logic [31:0] cmd_o,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready
);
  import dcc_pkg::*;

  localparam int unsigned OFF_W = 32 - CNT_W;

  eng_st_t          st_q, st_d;
  logic [31:0]      src_q, src_d, dst_q, dst_d, cmd_q, cmd_d;
  logic [31:0]      cur_q, cur_d, data_q, data_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [OFF_W-1:0] nxt_q, nxt_d;
  logic [1:0]       wd_q, wd_d;
  logic [4:0]       beat_q, beat_d;

  logic [2:0]  unit_lg;
  logic [1:0]  beat_lg;
  logic [4:0]  beats_m1;
  logic        code_ok;
  logic [6:0]  umask;
  logic        misal;
  logic [31:0] step;
  logic [31:0] link_addr;

  dcc_unit_decode u_dec (
    .code     (cmd_q[10:8]),
    .unit_lg  (unit_lg),
    .beat_lg  (beat_lg),
    .beats_m1 (beats_m1),
    .code_ok  (code_ok)
  );

  assign umask     = 7'((8'd1 << unit_lg) - 8'd1);
  assign misal     = (|(src_q[6:0] & umask)) | (|(dst_q[6:0] & umask));
  assign step      = 32'd1 << beat_lg;
  assign link_addr = desc_base + {{(32-OFF_W-4){1'b0}}, nxt_q, 4'b0000};

  always_comb begin
    st_d       = st_q;
    src_d      = src_q;
    dst_d      = dst_q;
    cmd_d      = cmd_q;
    cur_d      = cur_q;
    data_d     = data_q;
    cnt_d      = cnt_q;
    nxt_d      = nxt_q;
    wd_d       = wd_q;
    beat_d     = beat_q;
    fetch_take = 1'b0;
    ev_tc      = 1'b0;
    ev_err     = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = src_q;
    mem_size   = beat_lg;
    mem_wdata  = data_q;
    case (st_q)
      E_IDLE: begin
        if (sw_we) begin
          case (sw_idx)
            RW_SRC: src_d = sw_wdata;
            RW_DST: dst_d = sw_wdata;
            RW_CNT: {nxt_d, cnt_d} = sw_wdata;
            RW_CMD: cmd_d = sw_wdata;
            default: ;
          endcase
        end
        if (fetch_pend) begin
          fetch_take = 1'b1;
          cur_d      = desc_base;
          wd_d       = 2'd0;
          st_d       = E_FETCH;
        end
      end
      E_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + {28'd0, wd_q, 2'b00};
        mem_size = 2'd2;
        if (mem_ready) begin
          case (wd_q)
            2'd0: cmd_d = mem_rdata;
            2'd1: src_d = mem_rdata;
            2'd2: dst_d = mem_rdata;
            default: {nxt_d, cnt_d} = mem_rdata;
          endcase
          wd_d = wd_q + 2'd1;
          if (wd_q == 2'd3) st_d = E_RUN;
        end
      end
      E_RUN: begin
        if (abort_req) begin
          st_d = E_IDLE;
        end else if (en && auto_mode) begin
          if (cnt_q == '0) begin
            if (cmd_q[CB_LINK]) begin
              cur_d = link_addr;
              wd_d  = 2'd0;
              st_d  = E_FETCH;
            end else begin
              ev_tc = 1'b1;
              st_d  = E_IDLE;
            end
          end else if (!code_ok || misal) begin
            ev_err = 1'b1;
            st_d   = E_IDLE;
          end else begin
            beat_d = beats_m1;
            st_d   = E_RD;
          end
        end
      end
      E_RD: begin
        mem_req  = 1'b1;
        mem_addr = src_q;
        if (mem_ready) begin
          data_d = mem_rdata;
          if (cmd_q[CB_SINC]) src_d = src_q + step;
          st_d = E_WR;
        end
      end
      E_WR: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_addr = dst_q;
        if (mem_ready) begin
          if (cmd_q[CB_DINC]) dst_d = dst_q + step;
          if (beat_q == 5'd0) begin
            cnt_d = cnt_q - CNT_W'(1);
            st_d  = E_RUN;
          end else begin
            beat_d = beat_q - 5'd1;
            st_d   = E_RD;
          end
        end
      end
      default: st_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      cmd_q  <= '0;
      cur_q  <= '0;
      data_q <= '0;
      cnt_q  <= '0;
      nxt_q  <= '0;
      wd_q   <= '0;
      beat_q <= '0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      cmd_q  <= cmd_d;
      cur_q  <= cur_d;
      data_q <= data_d;
      cnt_q  <= cnt_d;
      nxt_q  <= nxt_d;
      wd_q   <= wd_d;
      beat_q <= beat_d;
    end
  end

  assign idle  = (st_q == E_IDLE);
  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = {nxt_q, cnt_q};
  assign cmd_o = cmd_q;

  AST_FETCH_IS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_FETCH) |-> (mem_req && !mem_we && mem_size == 2'd2)) else $error("bad fetch"); // R2
  AST_UNIT_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == E_WR && mem_ready && beat_q == 5'd0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)))
    else $error("count step"); // R3
  AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ((mem_addr[1:0] & 2'(step - 32'd1)) == 2'b00))
    else $error("unaligned write"); // R8
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan #(
  parameter int unsigned CNT_W = 24,
  parameter int unsigned RT_W  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_word,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        doorbell,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ready,
  output logic        irq
);
  import dcc_pkg::*;

  logic            en, auto_mode, fetch_pend, abort_req;
  logic            fetch_take, ev_tc, ev_err, eng_idle;
  logic [31:0]     desc_base, status, src_v, dst_v, cnt_v, cmd_v;
  logic [RT_W-1:0] rtype;

  dcc_ctrl_regs #(.RT_W(RT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_rtyp    (reg_we && reg_word == RW_RTYP),
    .we_stat    (reg_we && reg_word == RW_STAT),
    .we_base    (reg_we && reg_word == RW_BASE),
    .wdata      (reg_wdata),
    .doorbell   (doorbell),
    .fetch_take (fetch_take),
    .ev_tc      (ev_tc),
    .ev_err     (ev_err),
    .eng_idle   (eng_idle),
    .tie        (cmd_v[CB_TIE]),
    .en         (en),
    .auto_mode  (auto_mode),
    .fetch_pend (fetch_pend),
    .abort_req  (abort_req),
    .desc_base  (desc_base),
    .rtype      (rtype),
    .status     (status),
    .irq        (irq)
  );

  dcc_engine #(.CNT_W(CNT_W)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .auto_mode  (auto_mode),
    .fetch_pend (fetch_pend),
    .abort_req  (abort_req),
    .desc_base  (desc_base),
    .sw_we      (reg_we),
    .sw_idx     (reg_word),
    .sw_wdata   (reg_wdata),
    .fetch_take (fetch_take),
    .ev_tc      (ev_tc),
    .ev_err     (ev_err),
    .idle       (eng_idle),
    .src_o      (src_v),
    .dst_o      (dst_v),
    .cnt_o      (cnt_v),
    .cmd_o      (cmd_v),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ready  (mem_ready)
  );

  always_comb begin
    case (reg_word)
      RW_SRC:  reg_rdata = src_v;
      RW_DST:  reg_rdata = dst_v;
      RW_CNT:  reg_rdata = cnt_v;
      RW_RTYP: reg_rdata = {{(32-RT_W){1'b0}}, rtype};
      RW_STAT: reg_rdata = status;
      RW_CMD:  reg_rdata = cmd_v;
      RW_BASE: reg_rdata = desc_base;
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: tb/sim_dma_chain_chan.sv
`timescale 1ns/1ps
module sim_dma_chain_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_word = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        doorbell = 1'b0;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        mem_ready;

  always #4 clk = ~clk;

  dma_chain_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .doorbell(doorbell),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready), .irq(irq)
  );

  // ---------------- memory model ----------------
  logic [7:0]  mem [0:2047];
  logic        pk_en = 1'b0, pk_fill = 1'b0;
  logic [10:0] pk_a = '0;
  logic [31:0] pk_w = '0;
  logic [7:0]  pk_seed = '0;
  logic        stall_en = 1'b0;
  logic        stall_t = 1'b0;
  int          writes = 0, watch_cnt = 0, irq_edges = 0, cyc = 0;
  logic [31:0] watch_addr = 32'hFFFF_FFFF;
  logic        irq_prev = 1'b0;

  function automatic logic [7:0] pat(input logic [10:0] a, input logic [7:0] s);
    return (a[7:0] ^ {a[10:8], 5'b0}) + s;
  endfunction

  assign mem_ready = stall_en ? stall_t : 1'b1;

  wire [10:0] ma = mem_addr[10:0];
  always_comb begin
    case (mem_size)
      2'd0:    mem_rdata = {24'd0, mem[ma]};
      2'd1:    mem_rdata = {16'd0, mem[ma + 11'd1], mem[ma]};
      default: mem_rdata = {mem[ma + 11'd3], mem[ma + 11'd2], mem[ma + 11'd1], mem[ma]};
    endcase
  end

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    stall_t  <= ~stall_t;
    irq_prev <= irq;
    if (irq && !irq_prev) irq_edges <= irq_edges + 1;
    if (pk_fill) for (int i = 0; i < 2048; i++) mem[i] <= pat(11'(i), pk_seed);
    if (pk_en) begin
      mem[pk_a]         <= pk_w[7:0];
      mem[pk_a + 11'd1] <= pk_w[15:8];
      mem[pk_a + 11'd2] <= pk_w[23:16];
      mem[pk_a + 11'd3] <= pk_w[31:24];
    end
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        writes <= writes + 1;
        mem[ma] <= mem_wdata[7:0];
        if (mem_size != 2'd0) mem[ma + 11'd1] <= mem_wdata[15:8];
        if (mem_size == 2'd2) begin
          mem[ma + 11'd2] <= mem_wdata[23:16];
          mem[ma + 11'd3] <= mem_wdata[31:24];
        end
      end else if (mem_addr == watch_addr && mem_size == 2'd2) begin
        watch_cnt <= watch_cnt + 1;
      end
    end
  end

  // ---------------- bookkeeping ----------------
  int errors = 0, checks = 0;
  logic done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [7:0] s);
    @(negedge clk); pk_seed = s; pk_fill = 1'b1;
    @(negedge clk); pk_fill = 1'b0;
  endtask

  task automatic poke(input logic [10:0] a, input logic [31:0] w);
    @(negedge clk); pk_a = a; pk_w = w; pk_en = 1'b1;
    @(negedge clk); pk_en = 1'b0;
  endtask

  task automatic put_desc(input logic [10:0] a, input logic [31:0] c, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] n);
    poke(a, c); poke(a + 11'd4, s); poke(a + 11'd8, d); poke(a + 11'd12, n);
  endtask

  function automatic logic [31:0] mkcmd(input bit link, input bit tie, input logic [2:0] tsz,
                                        input bit sinc, input bit dinc);
    return (32'(sinc) << 23) | (32'(dinc) << 22) | (32'(tsz) << 8) | (32'(tie) << 1) | 32'(link);
  endfunction

  task automatic wr(input logic [2:0] w, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_word = w; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [31:0] d);
    @(negedge clk); reg_word = w; #1 d = reg_rdata;
  endtask

  task automatic ring();
    @(negedge clk); doorbell = 1'b1;
    @(negedge clk); doorbell = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_end(input int limit);
    logic [31:0] s;
    for (int i = 0; i < limit; i++) begin
      rd(3'd4, s);
      if (s[3] || s[4]) break;
    end
  endtask

  task automatic chk_copy(input string req, input logic [10:0] s, input logic [10:0] d,
                          input int n, input logic [7:0] seed);
    int bad = -1;
    for (int i = 0; i < n; i++)
      if (mem[d + 11'(i)] !== pat(s + 11'(i), seed) && bad < 0) bad = i;
    if (bad < 0) check(req, 0, 0);
    else check(req, {21'd0, d + 11'(bad)}, 32'hFFFF_FFFF);
  endtask

  task automatic start_desc(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] n);
    wr(3'd4, 32'd0);
    put_desc(11'h100, c, s, d, n);
    wr(3'd6, 32'h100);
    ring();
    idle_cycles(8);
    wr(3'd4, 32'd1);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      rd(3'(w), v);
      check("R1 register reset", v, 0);
    end
    check("R1 irq reset", {31'd0, irq}, 0);
    check("R1 mem_req reset", {31'd0, mem_req}, 0);
  endtask

  task automatic t_fetch_and_copy();
    logic [31:0] v, c;
    fill(8'h11);
    c = mkcmd(0, 1, 3'd0, 1, 1);
    wr(3'd3, 32'h8);
    put_desc(11'h100, c, 32'h400, 32'h600, 32'h0000_0004);
    wr(3'd6, 32'h100);
    ring();
    idle_cycles(10);
    rd(3'd5, v); check("R2 command word", v, c);
    rd(3'd0, v); check("R2 source word", v, 32'h400);
    rd(3'd1, v); check("R2 target word", v, 32'h600);
    rd(3'd2, v); check("R2 count word", v, 32'h4);
    check("R2 no data moved before enable", {24'd0, mem[11'h600]}, {24'd0, pat(11'h600, 8'h11)});
    wr(3'd4, 32'd1);
    wait_end(200);
    chk_copy("R3 copied 16 bytes", 11'h400, 11'h600, 16, 8'h11);
    check("R3 byte past end untouched", {24'd0, mem[11'h610]}, {24'd0, pat(11'h610, 8'h11)});
    rd(3'd2, v); check("R3 count zero", v, 0);
    rd(3'd0, v); check("R3 source advanced", v, 32'h410);
    rd(3'd1, v); check("R3 target advanced", v, 32'h610);
    rd(3'd4, v); check("R7 terminal count", v & 32'h1C, 32'h08);
    check("R7 irq with tie", {31'd0, irq}, 1);
    wr(3'd4, 32'd0);
    rd(3'd4, v); check("R9 status cleared", v, 0);
    check("R9 irq dropped", {31'd0, irq}, 0);
  endtask

  task automatic t_sizes();
    logic [31:0] v;
    logic [2:0] codes [6] = '{3'd1, 3'd2, 3'd0, 3'd3, 3'd4, 3'd5};
    int units [6] = '{1, 2, 4, 16, 32, 64};
    for (int k = 0; k < 7; k++) begin
      logic [2:0] cd = (k < 6) ? codes[k] : 3'd6;
      int u = (k < 6) ? units[k] : 128;
      fill(8'(k * 13 + 5));
      start_desc(mkcmd(0, 1, cd, 1, 1), 32'h400, 32'h600, 32'd2);
      wait_end(2000);
      chk_copy($sformatf("R4 size code %0d", cd), 11'h400, 11'h600, 2 * u, 8'(k * 13 + 5));
      check($sformatf("R4 no overrun code %0d", cd), {24'd0, mem[11'h600 + 11'(2 * u)]},
            {24'd0, pat(11'h600 + 11'(2 * u), 8'(k * 13 + 5))});
      rd(3'd0, v); check($sformatf("R4 source step code %0d", cd), v, 32'h400 + 32'(2 * u));
    end
  endtask

  task automatic t_fixed();
    logic [31:0] v;
    fill(8'h33);
    start_desc(mkcmd(0, 1, 3'd1, 1, 0), 32'h400, 32'h600, 32'd3);
    wait_end(200);
    check("R5 fixed target holds last byte", {24'd0, mem[11'h600]}, {24'd0, pat(11'h402, 8'h33)});
    check("R5 fixed target neighbour", {24'd0, mem[11'h601]}, {24'd0, pat(11'h601, 8'h33)});
    rd(3'd1, v); check("R5 target register fixed", v, 32'h600);
    rd(3'd0, v); check("R5 source register advanced", v, 32'h403);
  endtask

  task automatic t_no_tie();
    logic [31:0] v;
    fill(8'h44);
    start_desc(mkcmd(0, 0, 3'd0, 1, 1), 32'h400, 32'h600, 32'd1);
    wait_end(200);
    rd(3'd4, v); check("R7 terminal count without tie", v & 32'h08, 32'h08);
    check("R7 no irq without tie", {31'd0, irq}, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    fill(8'h55);
    wr(3'd4, 32'd0);
    put_desc(11'h100, mkcmd(1, 1, 3'd0, 1, 1), 32'h400, 32'h600, 32'h0200_0002);
    put_desc(11'h120, mkcmd(0, 1, 3'd1, 1, 1), 32'h480, 32'h700, 32'h0000_0005);
    wr(3'd6, 32'h100);
    ring();
    idle_cycles(8);
    irq_edges = 0;
    wr(3'd4, 32'd1);
    wait_end(400);
    idle_cycles(2);
    chk_copy("R6 first link copied", 11'h400, 11'h600, 8, 8'h55);
    chk_copy("R6 second link copied", 11'h480, 11'h700, 5, 8'h55);
    check("R6 single irq for chain", 32'(irq_edges), 1);
    rd(3'd5, v); check("R6 second descriptor loaded", v, mkcmd(0, 1, 3'd1, 1, 1));
  endtask

  task automatic t_misalign();
    logic [31:0] v;
    fill(8'h66);
    writes = 0;
    start_desc(mkcmd(0, 0, 3'd0, 1, 1), 32'h402, 32'h600, 32'd2);
    wait_end(200);
    rd(3'd4, v); check("R8 error and halt, enable cleared", v & 32'h1D, 32'h14);
    check("R8 irq on error", {31'd0, irq}, 1);
    check("R8 no data written", 32'(writes), 0);
    rd(3'd2, v); check("R8 count untouched", v, 32'd2);
    wr(3'd4, 32'd0);
    check("R9 irq cleared after error", {31'd0, irq}, 0);
  endtask

  task automatic t_code7();
    logic [31:0] v;
    writes = 0;
    start_desc(mkcmd(0, 0, 3'd7, 1, 1), 32'h400, 32'h600, 32'd1);
    wait_end(200);
    rd(3'd4, v); check("R12 illegal size is error", v & 32'h14, 32'h14);
    check("R12 no data written", 32'(writes), 0);
    wr(3'd4, 32'd0);
  endtask

  task automatic t_rtype();
    logic [31:0] v;
    fill(8'h77);
    writes = 0;
    wr(3'd3, 32'h0);
    start_desc(mkcmd(0, 1, 3'd0, 1, 1), 32'h400, 32'h600, 32'd3);
    idle_cycles(60);
    check("R10 no data without auto request", 32'(writes), 0);
    rd(3'd2, v); check("R10 count unchanged", v, 32'd3);
    wr(3'd4, 32'd0);
    wr(3'd3, 32'h8);
    idle_cycles(3);
  endtask

  task automatic t_loop();
    int snap;
    fill(8'h88);
    wr(3'd4, 32'd0);
    put_desc(11'h100, mkcmd(1, 1, 3'd1, 1, 1), 32'h400, 32'h600, 32'h0100_0001);
    put_desc(11'h110, mkcmd(1, 1, 3'd1, 1, 1), 32'h480, 32'h700, 32'h0000_0001);
    watch_addr = 32'h100;
    watch_cnt = 0;
    irq_edges = 0;
    wr(3'd6, 32'h100);
    ring();
    idle_cycles(8);
    wr(3'd4, 32'd1);
    idle_cycles(80);
    check("R11 loop refetches first descriptor", 32'(watch_cnt >= 3), 1);
    check("R11 loop raises no irq", 32'(irq_edges), 0);
    wr(3'd4, 32'd0);
    idle_cycles(20);
    snap = watch_cnt;
    idle_cycles(60);
    check("R9 abort stops loop", 32'(watch_cnt), 32'(snap));
    watch_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_abort_mid();
    logic [31:0] v;
    int units;
    fill(8'h99);
    stall_en = 1'b1;
    start_desc(mkcmd(0, 1, 3'd6, 1, 1), 32'h400, 32'h600, 32'd4);
    writes = 0;
    idle_cycles(150);
    wr(3'd4, 32'd0);
    idle_cycles(400);
    units = writes / 32;
    check("R9 abort on unit boundary", 32'(writes % 32), 0);
    check("R9 some units moved", 32'(units > 0 && units < 4), 1);
    rd(3'd2, v); check("R9 count matches moved units", v, 32'(4 - units));
    rd(3'd4, v); check("R9 no terminal count after abort", v, 0);
    stall_en = 1'b0;
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    idle_cycles(2);
    t_reset();
    t_fetch_and_copy();
    t_sizes();
    t_fixed();
    t_no_tie();
    t_chain();
    t_misalign();
    t_code7();
    t_rtype();
    t_loop();
    t_abort_mid();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R3: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule